// File: doc/BRIEF.md
# Fine-Adjust 8-Bit Reload Timer

This block is an 8-bit down-counting reload timer for use as a baud-rate source. A count-clock enable input advances the counter one step at a time. When the counter steps below zero it reloads from a programmable reload value and raises an underflow pulse and an interrupt request, each one system clock wide. On the same event it toggles a divided output clock.

A plain reload timer can only produce whole-count periods. This timer also has a fine mode for smaller steps. Underflows are grouped into frames of sixteen. A 4-bit fine value F lengthens F of the sixteen intervals in each frame by one count-clock enable. The mean period can therefore be tuned in sixteenths of a count. The lengthened intervals are spread evenly across the frame. A larger F keeps every interval that a smaller F lengthened and adds more.

Software controls the timer through two 16-bit registers. The control register holds run/stop, a write-only restart strobe, a one-shot/repeat select and the fine value. The reload register holds the 8-bit reload value.

Top module: `fine_timer8`

## Requirements
- R1: After reset, both registers read 0 and `uflow_pulse`, `irq_req` and `clk_out` are low.
- R2: With `reg_addr`=0, the control register reads as follows: run in bit 0, one-shot select in bit 4, fine value in bits 11:8. Bit 1 (restart) and all other bits read 0, whatever was written to them. With `reg_addr`=1, the reload value reads in bits 7:0 and the upper bits read 0.
- R3: With a fine value of 0 and run set, each underflow interval is exactly reload+1 count enables. Enables that arrive while run is 0 have no effect on the count.
- R4: Let i be the interval's position in its frame (0 to 15) and F the fine value active for that frame. The interval is lengthened by one enable exactly when the 4-bit bit-reversal of i is less than F.
- R5: Writing 1 to control bit 1 loads the counter from the reload register and restarts the frame at position 0, using the fine value written in the same write. Writing 0 to that bit leaves the count in progress untouched.
- R6: A fine value written without a restart takes effect at the first interval of the next frame. The frame in progress keeps its old pattern.
- R7: An underflow produces `uflow_pulse` and `irq_req` together, in the system clock after the enable that completes the interval. A delayed interval delays both signals by the same extra enable. Without a further underflow, both signals are low in the following clock.
- R8: `clk_out` toggles on every underflow and on nothing else.
- R9: In one-shot mode (bit 4 = 1), the run bit clears at the first underflow. Further enables then produce no underflow.
- R10: In repeat mode (bit 4 = 0), the counter reloads after every underflow and run stays set.
- R11: Clearing run freezes the count partway through an interval. Setting run again resumes the remaining count, with no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count-clock enable, one step per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 reload |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| uflow_pulse | output | 1 | One-clock underflow pulse |
| irq_req | output | 1 | One-clock interrupt request |
| clk_out | output | 1 | Output clock, toggled per underflow |

## Verification
Directed frames at full enable density, with reload values 0, 2 and 5 and fine values 0, 8 and 15, show each interval's length at every frame position. These runs separate a correct bit-reversed spread from a shifted or inverted pattern, and from an off-by-one count. Random enable gaps combined with random reload and fine values show that intervals are counted in enables, not in clocks. A fine write made partway through a frame, and a restart made partway through an interval, show whether the pattern changes at the frame boundary and whether the frame position resets. Stop/resume, one-shot and repeat sequences distinguish a frozen count from a reloaded one, and a cleared run bit from one that stays set.

// File: rtl/fine_timer8_pkg.sv
package fine_timer8_pkg;
    localparam int REG_W      = 16;
    localparam int FINE_W     = 4;
    localparam int FINE_LSB   = 8;
    localparam int BIT_RUN    = 0;
    localparam int BIT_RSTRT  = 1;
    localparam int BIT_ONESH  = 4;
    localparam logic ADDR_CTRL   = 1'b0;
    localparam logic ADDR_RELOAD = 1'b1;
endpackage

// File: rtl/fine_timer8_regs.sv
module fine_timer8_regs
    import fine_timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               addr,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    input  logic               stop_req,
    output logic               run_o,
    output logic               oneshot_o,
    output logic [FINE_W-1:0]  fine_o,
    output logic [FINE_W-1:0]  fine_new_o,
    output logic [CNT_W-1:0]   reload_o,
    output logic               restart_o
);
    typedef struct packed {
        logic              run;
        logic              oneshot;
        logic [FINE_W-1:0] fine;
        logic [CNT_W-1:0]  reload;
    } regs_t;

    regs_t s_d, s_q;
    logic  restart_d;

    always_comb begin
        s_d       = s_q;
        restart_d = 1'b0;
        if (stop_req) begin
            s_d.run = 1'b0;
        end
        if (wr_en && addr == ADDR_CTRL) begin
            s_d.run     = wdata[BIT_RUN];
            s_d.oneshot = wdata[BIT_ONESH];
            s_d.fine    = wdata[FINE_LSB +: FINE_W];
            restart_d   = wdata[BIT_RSTRT];
        end
        if (wr_en && addr == ADDR_RELOAD) begin
            s_d.reload = wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata[BIT_RUN]              = s_q.run;
            rdata[BIT_ONESH]            = s_q.oneshot;
            rdata[FINE_LSB +: FINE_W]   = s_q.fine;
        end else begin
            rdata[CNT_W-1:0]            = s_q.reload;
        end
    end

    logic unused_wbits;
    assign unused_wbits = ^wdata;

    assign run_o      = s_q.run;
    assign oneshot_o  = s_q.oneshot;
    assign fine_o     = s_q.fine;
    assign fine_new_o = s_d.fine;
    assign reload_o   = s_q.reload;
    assign restart_o  = restart_d;

    // R9: a one-shot stop clears run unless software rewrites it in the same cycle
    a_r9_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !wr_en) |=> !s_q.run);
endmodule

// File: rtl/fine_timer8_frame.sv
module fine_timer8_frame
    import fine_timer8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [FINE_W-1:0] fine_new,
    input  logic [FINE_W-1:0] fine_cur,
    input  logic              uf_evt,
    output logic              delay_req
);
    localparam logic [FINE_W-1:0] IDX_LAST = '1;

    typedef struct packed {
        logic [FINE_W-1:0] idx;
        logic [FINE_W-1:0] fine_act;
    } frame_t;

    frame_t s_d, s_q;
    logic [FINE_W-1:0] idx_rev;

    always_comb begin
        for (int i = 0; i < FINE_W; i++) begin
            idx_rev[i] = s_q.idx[FINE_W-1-i];
        end
        delay_req = (idx_rev < s_q.fine_act);
    end

    always_comb begin
        s_d = s_q;
        if (restart) begin
            s_d.idx      = '0;
            s_d.fine_act = fine_new;
        end else if (uf_evt) begin
            s_d.idx = s_q.idx + 1'b1;
            if (s_q.idx == IDX_LAST) begin
                s_d.fine_act = fine_cur;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R6: the active pattern only changes at the start of a frame
    a_r6_pattern_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.fine_act) |-> (s_q.idx == '0));
endmodule

// File: rtl/fine_timer8_core.sv
module fine_timer8_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    input  logic             oneshot,
    input  logic             delay_req,
    output logic             uf_evt,
    output logic             stop_req,
    output logic             uflow,
    output logic             irq,
    output logic             clk_out
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stall;
        logic             uf;
        logic             irq;
        logic             clko;
    } core_t;

    core_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.uf  = 1'b0;
        s_d.irq = 1'b0;
        uf_evt  = 1'b0;
        if (restart) begin
            s_d.cnt   = reload;
            s_d.stall = 1'b0;
        end else if (run && tick) begin
            if (s_q.cnt != '0) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end else if (delay_req && !s_q.stall) begin
                s_d.stall = 1'b1;
            end else begin
                uf_evt    = 1'b1;
                s_d.stall = 1'b0;
                s_d.cnt   = reload;
                s_d.uf    = 1'b1;
                s_d.irq   = 1'b1;
                s_d.clko  = ~s_q.clko;
            end
        end
        stop_req = uf_evt && oneshot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign uflow   = s_q.uf;
    assign irq     = s_q.irq;
    assign clk_out = s_q.clko;

    // R11: a stopped timer holds its count
    a_r11_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(s_q.cnt));
    // R4: the extra step is only ever taken at the bottom of the count
    a_r4_stall_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stall |-> (s_q.cnt == '0));
    // R8: output clock moves only with an underflow
    a_r8_clk_only_on_uflow: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.uf |-> (s_q.clko == $past(s_q.clko)));
endmodule

// File: rtl/fine_timer8.sv
module fine_timer8
    import fine_timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              uflow_pulse,
    output logic              irq_req,
    output logic              clk_out
);
    logic              run_w, oneshot_w, restart_w, stop_w, uf_evt_w, delay_w;
    logic [FINE_W-1:0] fine_w, fine_new_w;
    logic [CNT_W-1:0]  reload_w;

    fine_timer8_regs #(.CNT_W(CNT_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .stop_req   (stop_w),
        .run_o      (run_w),
        .oneshot_o  (oneshot_w),
        .fine_o     (fine_w),
        .fine_new_o (fine_new_w),
        .reload_o   (reload_w),
        .restart_o  (restart_w)
    );

    fine_timer8_frame i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart_w),
        .fine_new  (fine_new_w),
        .fine_cur  (fine_w),
        .uf_evt    (uf_evt_w),
        .delay_req (delay_w)
    );

    fine_timer8_core #(.CNT_W(CNT_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_en),
        .run       (run_w),
        .restart   (restart_w),
        .reload    (reload_w),
        .oneshot   (oneshot_w),
        .delay_req (delay_w),
        .uf_evt    (uf_evt_w),
        .stop_req  (stop_w),
        .uflow     (uflow_pulse),
        .irq       (irq_req),
        .clk_out   (clk_out)
    );

    // R7: interrupt request always accompanies the underflow pulse
    a_r7_irq_with_uflow: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_pulse == irq_req);
    // R9: after a one-shot underflow the timer is no longer running
    a_r9_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow_pulse && oneshot_w && !$past(reg_wr)) |-> !run_w);
endmodule

// File: tb/test_fine_timer8.sv
`timescale 1ns/1ps
module test_fine_timer8;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        uflow_pulse, irq_req, clk_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    int m_idx, m_fine_act, m_fine_pend, m_reload;
    bit m_clk = 0;
    bit prev_saw = 0;

    always #2.5 clk = ~clk;

    fine_timer8 i_fine_timer8 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .uflow_pulse(uflow_pulse), .irq_req(irq_req), .clk_out(clk_out)
    );

    function automatic int rev4(int v);
        return ((v & 1) << 3) | ((v & 2) << 1) | ((v & 4) >> 1) | ((v & 8) >> 3);
    endfunction

    function automatic int exp_len(int idx, int fine, int reload);
        return reload + 1 + ((rev4(idx) < fine) ? 1 : 0);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    task automatic rd(input bit a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wr(input bit a, input int data);
        cnt_en    = 1'b0;
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = data[15:0];
        @(negedge clk);
        reg_wr    = 1'b0;
        prev_saw  = uflow_pulse;
    endtask

    // control write; reserved bits are always written as ones
    task automatic wr_ctrl(int fine, bit oneshot, bit restart, bit run);
        wr(1'b0, 16'hF0EC | (fine << 8) | (int'(oneshot) << 4) | (int'(restart) << 1) | int'(run));
        m_fine_pend = fine;
        if (restart) begin
            m_idx      = 0;
            m_fine_act = fine;
        end
    endtask

    task automatic setup(int reload, int fine, bit oneshot);
        wr(1'b1, 16'hA500 | reload);
        m_reload = reload;
        wr_ctrl(fine, oneshot, 1'b1, 1'b1);
    endtask

    task automatic step(input bit en, output bit saw);
        cnt_en = en;
        @(negedge clk);
        saw = uflow_pulse;
        chk("R7 irq matches pulse", int'(irq_req), int'(uflow_pulse));
        if (prev_saw && !en) chk("R7 pulse one clock wide", int'(uflow_pulse), 0);
        if (saw) begin
            m_clk = ~m_clk;
            chk("R8 clk_out toggle", int'(clk_out), int'(m_clk));
        end
        prev_saw = saw;
    endtask

    task automatic measure(int n, int pct);
        for (int p = 0; p < n; p++) begin
            int  cnt = 0;
            int  guard = 0;
            bit  saw = 0;
            while (!saw && guard < 20000) begin
                bit en = (($urandom % 100) < pct);
                step(en, saw);
                cnt += int'(en);
                guard++;
            end
            chk($sformatf("R3/R4 interval pos %0d fine %0d", m_idx, m_fine_act),
                cnt, exp_len(m_idx, m_fine_act, m_reload));
            m_idx = (m_idx + 1) % 16;
            if (m_idx == 0) m_fine_act = m_fine_pend;
        end
    endtask

    task automatic quiet(int n, string req);
        int pulses = 0;
        for (int k = 0; k < n; k++) begin
            bit saw;
            step(1'b1, saw);
            pulses += int'(saw);
        end
        chk(req, pulses, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); chk("R1 ctrl reset", v, 0);
        rd(1'b1, v); chk("R1 reload reset", v, 0);
        chk("R1 uflow low", int'(uflow_pulse), 0);
        chk("R1 irq low", int'(irq_req), 0);
        chk("R1 clk_out low", int'(clk_out), 0);

        // R2 read-back; reserved and restart bits read 0
        wr(1'b1, 16'hFF15);
        rd(1'b1, v); chk("R2 reload readback", v, 16'h0015);
        wr_ctrl(15, 1'b1, 1'b1, 1'b0);
        rd(1'b0, v); chk("R2 ctrl readback", v, 16'h0F10);

        // R3 plain intervals, R4 corner patterns
        setup(5, 0, 1'b0);
        measure(16, 100);
        setup(0, 15, 1'b0);
        measure(32, 100);
        setup(2, 8, 1'b0);
        measure(16, 50);

        // R10 repeat keeps running
        rd(1'b0, v); chk("R10 run still set", v & 1, 1);

        // R6 fine write mid-frame applies next frame
        setup(3, 2, 1'b0);
        measure(5, 100);
        wr_ctrl(12, 1'b0, 1'b0, 1'b1);
        measure(27, 80);

        // R11 stop and resume; R5 restart bit 0 does nothing
        setup(10, 0, 1'b0);
        begin
            bit saw;
            for (int k = 0; k < 4; k++) step(1'b1, saw);
        end
        wr_ctrl(0, 1'b0, 1'b0, 1'b0);
        quiet(30, "R11 no pulse while stopped");
        wr_ctrl(0, 1'b0, 1'b0, 1'b1);
        begin
            int cnt = 0;
            bit saw = 0;
            while (!saw && cnt < 100) begin
                step(1'b1, saw);
                cnt++;
            end
            chk("R11/R5 remaining count after resume", cnt, 7);
            m_idx = 1;
        end

        // R5 restart mid-interval reloads and resets frame position
        setup(4, 5, 1'b0);
        measure(3, 100);
        begin
            bit saw;
            for (int k = 0; k < 3; k++) step(1'b1, saw);
        end
        wr_ctrl(5, 1'b0, 1'b1, 1'b1);
        measure(16, 100);

        // R9 one-shot
        setup(3, 0, 1'b1);
        measure(1, 100);
        rd(1'b0, v); chk("R9 run cleared", v, 16'h0010);
        quiet(50, "R9 no pulse after one-shot");

        // random trials
        for (int t = 0; t < 6; t++) begin
            int rl = $urandom % 16;
            int fn = $urandom % 16;
            int pc = 30 + ($urandom % 71);
            setup(rl, fn, 1'b0);
            measure(7, pc);
            wr_ctrl($urandom % 16, 1'b0, 1'b0, 1'b1);
            measure(25, pc);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule